// File: doc/BRIEF.md
# Converter Power and Gain Sequencer

This block drives the two active-low shutdown pins and the two-bit span-select code of a sampling converter. It also produces a `ready` flag that tells the capture controller when a conversion may start. A power command chooses between running, a light shutdown that keeps the reference alive, and a deep shutdown. A gain command asks for one of four input spans. The block puts each command onto the pins and then holds `ready` low for a settling interval. That interval depends on which shutdown mode is being left, or on which span is entered and from where.

The delays are all parameters counted in clock cycles, so one build can serve any clock rate. A span change is held back while the converter reports a conversion in progress. A command that arrives while a settling interval is running restarts the wait, using the delay of the newest transition.

Top module: `adc_pwr_gain_seq`

## Requirements
- R1: `pwr_req` uses bit 1 for a deep-shutdown request and bit 0 for a light-shutdown request. One clock after a request, the pins read: run (`pwr_req`=00) → `sleep_n`=1, `nap_n`=1; light (01) → `sleep_n`=1, `nap_n`=0; deep (10 or 11) → `sleep_n`=0, `nap_n`=1. When both bits are set, deep shutdown wins, and the two pins are never low together.
- R2: During reset and after it, the block sits in deep shutdown (`sleep_n`=0, `nap_n`=1) with `gain_code`=11 and `ready`=0.
- R3: On a move from deep shutdown to run, `ready` rises WAKE_SLEEP_CYC clock edges after the edge that raises `sleep_n`.
- R4: On a move from light shutdown to run, `ready` rises WAKE_NAP_CYC clock edges after the edge that raises `nap_n`.
- R5: `ready` stays 0 in every cycle in which either shutdown pin is low.
- R6: The span codes are 11 = 0 dB, 01 = −3 dB, 10 = −6 dB and 00 = −9 dB, with bit 0 as the first select pin and bit 1 as the second. When `conv_busy` is 0, `gain_code` takes the value of `gain_req` one clock after the two differ.
- R7: Entering −6 dB or −9 dB (new bit 0 = 0) holds `ready` low for GAIN_LOW_CYC edges.
- R8: Entering 0 dB from any span, or entering −3 dB from −6 dB or −9 dB, holds `ready` low for GAIN_UP_CYC edges.
- R9: Stepping from 0 dB to −3 dB holds `ready` low for GAIN_DOWN_CYC edges. When PULLDOWN_FITTED=1 the wait is GAIN_DOWN_PD_CYC instead.
- R10: While `conv_busy` is 1, `gain_code` does not change and `ready` is not disturbed by a pending gain request. The code is applied on the first edge at which `conv_busy` is 0.
- R11: A change applied while a wait is running restarts the wait with the delay of the new transition, even when that delay is shorter than the time left.
- R12: When a wake from shutdown and a span change are applied on the same edge, the wait is the larger of the two delays.
- R13: In the cycle after any applied change to `gain_code`, `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req | input | 2 | Power command: bit 1 deep shutdown, bit 0 light shutdown |
| gain_req | input | 2 | Requested span code |
| conv_busy | input | 1 | High while the converter is converting |
| sleep_n | output | 1 | Deep-shutdown pin, low = shut down |
| nap_n | output | 1 | Light-shutdown pin, low = shut down |
| gain_code | output | 2 | Applied span-select pins |
| ready | output | 1 | Conversions may start |

## Verification
The assertions check on every cycle that the pins follow the power request, that the two shutdown pins are never low together, that `ready` implies both pins are high, that the span code stays frozen while a conversion is running, and that `ready` is low right after a span change. The lengths of the waits can only be shown by the bench scenarios: each wake path, all twelve span transitions, a deferred change under `conv_busy`, a restart that shortens the wait, and simultaneous wake-plus-span changes. In each of these the bench counts the cycles until `ready` and compares the count with the delay it works out itself.

// File: rtl/adc_pgs_pkg.sv
package adc_pgs_pkg;

   typedef enum logic [1:0] {
      PM_RUN   = 2'd0,
      PM_LIGHT = 2'd1,
      PM_DEEP  = 2'd2
   } pwr_mode_t;

   // deep shutdown wins when both request bits are set
   function automatic pwr_mode_t decode_req(input logic [1:0] req);
      if (req[1])      return PM_DEEP;
      else if (req[0]) return PM_LIGHT;
      else             return PM_RUN;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_pgs_power_ctl.sv
module adc_pgs_power_ctl
   import adc_pgs_pkg::*;
#(
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned WAKE_DEEP  = 20,
   parameter int unsigned WAKE_LIGHT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       pwr_req,
   output pwr_mode_t        mode,
   output logic             wake_evt,
   output logic [CNT_W-1:0] wake_dly
);
   pwr_mode_t mode_q;
   pwr_mode_t req_mode;

   always_comb begin
      req_mode = decode_req(pwr_req);
      wake_evt = (req_mode == PM_RUN) && (mode_q != PM_RUN);
      wake_dly = (mode_q == PM_DEEP) ? CNT_W'(WAKE_DEEP) : CNT_W'(WAKE_LIGHT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= PM_DEEP;
      else        mode_q <= req_mode;
   end

   assign mode = mode_q;
endmodule

// File: rtl/adc_pgs_gain_ctl.sv
module adc_pgs_gain_ctl #(
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned LOW_DLY    = 12,
   parameter int unsigned UP_DLY     = 5,
   parameter int unsigned DOWN_DLY   = 9,
   parameter int unsigned DOWN_PD    = 4,
   parameter bit          PULLDOWN   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       gain_req,
   input  logic             conv_busy,
   output logic [1:0]       code,
   output logic             step_evt,
   output logic [CNT_W-1:0] step_dly
);
   logic [1:0]       code_q;
   logic [CNT_W-1:0] down_dly;

   generate
      if (PULLDOWN) begin : g_pd_fitted
         assign down_dly = CNT_W'(DOWN_PD);
      end else begin : g_pd_absent
         assign down_dly = CNT_W'(DOWN_DLY);
      end
   endgenerate

   always_comb begin
      step_evt = (gain_req != code_q) && !conv_busy;
      if (!gain_req[0])                              step_dly = CNT_W'(LOW_DLY);
      else if (gain_req == 2'b01 && code_q == 2'b11) step_dly = down_dly;
      else                                           step_dly = CNT_W'(UP_DLY);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_q <= 2'b11;
      else if (step_evt) code_q <= gain_req;
   end

   assign code = code_q;
endmodule

// File: rtl/adc_pgs_settle_timer.sv
module adc_pgs_settle_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= load_val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_pwr_gain_seq.sv
module adc_pwr_gain_seq
   import adc_pgs_pkg::*;
#(
   parameter int unsigned WAKE_SLEEP_CYC   = 500_000,
   parameter int unsigned WAKE_NAP_CYC     = 10,
   parameter int unsigned GAIN_LOW_CYC     = 30_000_000,
   parameter int unsigned GAIN_UP_CYC      = 150_000,
   parameter int unsigned GAIN_DOWN_CYC    = 20_000_000,
   parameter int unsigned GAIN_DOWN_PD_CYC = 5_000_000,
   parameter bit          PULLDOWN_FITTED  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pwr_req,
   input  logic [1:0] gain_req,
   input  logic       conv_busy,
   output logic       sleep_n,
   output logic       nap_n,
   output logic [1:0] gain_code,
   output logic       ready
);
   localparam int unsigned MAX_DLY = max2(max2(max2(WAKE_SLEEP_CYC, WAKE_NAP_CYC),
                                               max2(GAIN_LOW_CYC, GAIN_UP_CYC)),
                                          max2(GAIN_DOWN_CYC, GAIN_DOWN_PD_CYC));
   localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);

   if (WAKE_SLEEP_CYC < 1 || WAKE_NAP_CYC < 1 || GAIN_LOW_CYC < 1 ||
       GAIN_UP_CYC < 1 || GAIN_DOWN_CYC < 1 || GAIN_DOWN_PD_CYC < 1) begin : g_bad_dly
      $error("adc_pwr_gain_seq: every delay must be at least one cycle");
   end

   pwr_mode_t        mode;
   logic             wake_evt, step_evt, tmr_done, tmr_load;
   logic [CNT_W-1:0] wake_dly, step_dly, load_val;

   adc_pgs_power_ctl #(
      .CNT_W(CNT_W), .WAKE_DEEP(WAKE_SLEEP_CYC), .WAKE_LIGHT(WAKE_NAP_CYC)
   ) pwr_i (
      .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req),
      .mode(mode), .wake_evt(wake_evt), .wake_dly(wake_dly)
   );

   adc_pgs_gain_ctl #(
      .CNT_W(CNT_W), .LOW_DLY(GAIN_LOW_CYC), .UP_DLY(GAIN_UP_CYC),
      .DOWN_DLY(GAIN_DOWN_CYC), .DOWN_PD(GAIN_DOWN_PD_CYC), .PULLDOWN(PULLDOWN_FITTED)
   ) gain_i (
      .clk(clk), .rst_n(rst_n), .gain_req(gain_req), .conv_busy(conv_busy),
      .code(gain_code), .step_evt(step_evt), .step_dly(step_dly)
   );

   // a wake and a span step on the same edge share one wait: the longer one
   always_comb begin
      tmr_load = wake_evt || step_evt;
      load_val = '0;
      if (wake_evt) load_val = wake_dly;
      if (step_evt && step_dly > load_val) load_val = step_dly;
   end

   adc_pgs_settle_timer #(.CNT_W(CNT_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(load_val), .expired(tmr_done)
   );

   assign sleep_n = (mode != PM_DEEP);
   assign nap_n   = (mode != PM_LIGHT);
   assign ready   = (mode == PM_RUN) && tmr_done;
endmodule

// File: rtl/adc_pgs_checker.sv
module adc_pgs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] pwr_req,
   input logic       conv_busy,
   input logic       sleep_n,
   input logic       nap_n,
   input logic [1:0] gain_code,
   input logic       ready
);
   p_pins_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_req == 2'b00) |=> (sleep_n && nap_n));

   p_pins_deep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_req[1] |=> (!sleep_n && nap_n));

   p_pins_light_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_req == 2'b01) |=> (sleep_n && !nap_n));

   p_never_both_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_n || nap_n));

   p_ready_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (sleep_n && nap_n));

   p_gain_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_busy |=> $stable(gain_code));

   p_ready_drops_on_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gain_code) |-> !ready);
endmodule

bind adc_pwr_gain_seq adc_pgs_checker chk_i (
   .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .conv_busy(conv_busy),
   .sleep_n(sleep_n), .nap_n(nap_n), .gain_code(gain_code), .ready(ready)
);

// File: tb/adc_pwr_gain_seq_tb_top.sv
module adc_pwr_gain_seq_tb_top;
   localparam int WS = 20, WN = 3, LOW = 12, UP = 5, DOWN = 9, DPD = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pwr_req = 2'b10;
   logic [1:0] gain_req = 2'b11;
   logic       conv_busy = 1'b0;
   logic       sleep_n, nap_n, ready;
   logic [1:0] gain_code;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   adc_pwr_gain_seq #(
      .WAKE_SLEEP_CYC(WS), .WAKE_NAP_CYC(WN), .GAIN_LOW_CYC(LOW), .GAIN_UP_CYC(UP),
      .GAIN_DOWN_CYC(DOWN), .GAIN_DOWN_PD_CYC(DPD), .PULLDOWN_FITTED(1'b0)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .gain_req(gain_req),
      .conv_busy(conv_busy), .sleep_n(sleep_n), .nap_n(nap_n),
      .gain_code(gain_code), .ready(ready)
   );

   function automatic int span_wait(input logic [1:0] from, input logic [1:0] to);
      if (to == 2'b10 || to == 2'b00)       return LOW;   // R7
      if (from == 2'b11 && to == 2'b01)     return DOWN;  // R9
      return UP;                                        // R8
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // counts the falling edges with ready low after the applying edge (R13: must be >0)
   task automatic measure(input int exp, input string req);
      int n = 0;
      bit seen = 1'b0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (ready) begin seen = 1'b1; break; end
         n++;
      end
      check(seen && n == exp, req, n, exp);
   endtask

   task automatic settle();
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (ready) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2 reset state
      check(!sleep_n && nap_n, "R2 pins in reset", {sleep_n, nap_n}, 2'b01);
      check(gain_code == 2'b11 && !ready, "R2 gain/ready in reset", {gain_code, ready}, 3'b110);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!sleep_n && nap_n && !ready && gain_code == 2'b11, "R2 after reset",
            {sleep_n, nap_n, gain_code, ready}, 5'b01110);

      // R3 wake from deep shutdown
      pwr_req = 2'b00;
      measure(WS, "R3 deep wake");

      // R1/R5 light shutdown, then R4 wake
      pwr_req = 2'b01;
      @(negedge clk);
      check(sleep_n && !nap_n, "R1 light pins", {sleep_n, nap_n}, 2'b10);
      begin
         int hi = 0;
         for (int i = 0; i < 6; i++) begin @(negedge clk); if (ready) hi++; end
         check(hi == 0, "R5 ready low in light shutdown", hi, 0);
      end
      pwr_req = 2'b00;
      measure(WN, "R4 light wake");

      // R1 both requested -> deep
      pwr_req = 2'b11;
      @(negedge clk);
      check(!sleep_n && nap_n && !ready, "R1 deep priority", {sleep_n, nap_n, ready}, 3'b010);
      pwr_req = 2'b00;
      measure(WS, "R3 wake after both requested");

      // R6-R9 sweep of every span transition
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            if (a != b) begin
               gain_req = 2'(a);
               settle();
               gain_req = 2'(b);
               measure(span_wait(2'(a), 2'(b)), "R7 R8 R9 span wait");
               check(gain_code == 2'(b), "R6 span code", gain_code, b);
            end
         end
      end

      // R10 change held while busy
      gain_req = 2'b11;
      settle();
      conv_busy = 1'b1;
      gain_req = 2'b10;
      begin
         int bad = 0;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (gain_code != 2'b11 || !ready) bad++;
         end
         check(bad == 0, "R10 held while busy", bad, 0);
      end
      conv_busy = 1'b0;
      measure(LOW, "R10 applied after busy");
      check(gain_code == 2'b10, "R10 code after busy", gain_code, 2'b10);

      // R11 restart with a shorter wait
      gain_req = 2'b11;
      settle();
      gain_req = 2'b00;
      repeat (4) @(negedge clk);
      gain_req = 2'b01;
      measure(UP, "R11 restart shortens wait");

      // R12 wake and span step together
      pwr_req = 2'b10;
      repeat (3) @(negedge clk);
      pwr_req = 2'b00;
      gain_req = 2'b10;
      measure((WS > LOW) ? WS : LOW, "R12 deep wake with span step");
      pwr_req = 2'b01;
      repeat (3) @(negedge clk);
      pwr_req = 2'b00;
      gain_req = 2'b11;
      measure((WN > UP) ? WN : UP, "R12 light wake with span step");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule